// File: doc/BRIEF.md
# Bus-Master IDE Channel Status and Descriptor Base Registers

This block holds the per-channel status byte of a bus-master IDE controller and the 32-bit base pointer of its descriptor table, both reached through a simple 32-bit I/O register bus. Software reads engine activity, the simplex strap and two sticky event flags from the status byte. It also keeps two DMA-capable flags there for the two drives. The descriptor base and the two DMA-capable flags leave the block as outputs for the rest of the controller.

The status byte mixes three kinds of bit. Some bits only read live hardware state. Some are plain storage. The error and interrupt flags are sticky: hardware sets them, and software clears them by writing a one. The interrupt flag follows a rising edge of the drive interrupt line. That line is first taken through a two-flop synchronizer. A two-state machine then watches it: `EDGE_LOW` means the line is idle, and `EDGE_HIGH` means a rise was already reported. The transition `EDGE_LOW -> EDGE_HIGH` emits a one-cycle rise pulse. The transition `EDGE_HIGH -> EDGE_LOW` follows the synchronized line falling. Both states stay put otherwise.

The bus addresses 32-bit words. Word index 2 holds the status byte in bits 23:16, matching byte offset 0Ah. Word index 3 holds the descriptor base, matching byte offset 0Ch. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational.

Top module: `ide_bm_status_regs`

## Requirements
- R1: After reset the status byte reads 00h when `engine_active` and `simplex_strap` are low, and the descriptor base reads 0.
- R2: Status bit 0 (read bit 16 of word 2) always equals `engine_active`; writes do not change it.
- R3: Status bit 1 (read bit 17) is set one edge after an `error_pulse`; a write to word 2 with byte enable 2 set and write bit 17 at 1 clears it; writing 0 there leaves it set.
- R4: Status bit 2 (read bit 18) becomes 1 on the third rising clock edge after `drive_irq` rises, and is cleared by writing 1 to write bit 18; a line that stays high does not set it again.
- R5: When a hardware set of bit 1 or bit 2 falls on the same edge as a write-one clear of that bit, the bit stays set.
- R6: Status bits 4:3 (read bits 20:19) always read 0.
- R7: Status bits 5 and 6 (read bits 21 and 22) are read-write storage for drive 0 and drive 1 DMA capability, driven out on `dma_capable[0]` and `dma_capable[1]`.
- R8: Status bit 7 (read bit 23) always equals `simplex_strap` and ignores writes.
- R9: Word 3 stores bits 31:2 of the descriptor base; each byte is written only when its byte enable is set; bits 1:0 always read 0; the stored value is driven on `prd_base`.
- R10: Reads of word indices other than 2 and 3 return 0, and bits 15:0 and 31:24 of word 2 read 0.
- R11: A write to word 2 with byte enable 2 clear changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_word_addr | input | 2 | 32-bit word index within the channel window |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word_addr` |
| engine_active | input | 1 | Bus-master engine is running |
| error_pulse | input | 1 | One-cycle error event from the engine |
| drive_irq | input | 1 | Raw, asynchronous drive interrupt line |
| simplex_strap | input | 1 | Constant strap for simplex-only operation |
| prd_base | output | 32 | Stored descriptor table base, bits 1:0 zero |
| dma_capable | output | 2 | DMA-capable flags for drive 1 and drive 0 |

## Verification
Write results and error-flag sets are due right after the clock edge that takes them. The bench drives on the falling edge and reads shortly after the next rising edge. The interrupt flag passes through three registers: two synchronizer flops and the flag itself, with the edge machine beside them. So the bench checks that it is still clear after the first and second edges and set after the third. The set-beats-clear case places the clear write on exactly that third edge. Live bits 0 and 7 are read combinationally within the same cycle as the input change.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
    localparam int ADDR_W      = 2;
    localparam int DATA_W      = 32;
    localparam int BE_W        = DATA_W / 8;
    localparam int STATUS_IDX  = 2;
    localparam int BASE_IDX    = 3;
    localparam int STATUS_LANE = 2;
    localparam int SB_ACTIVE   = 0;
    localparam int SB_ERR      = 1;
    localparam int SB_IRQ      = 2;
    localparam int SB_DMA0     = 5;
    localparam int SB_DMA1     = 6;
    localparam int SB_SIMPLEX  = 7;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;
endpackage

// File: rtl/ide_irq_edge_fsm.sv
module ide_irq_edge_fsm
    import ide_bm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    edge_state_t            state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_async};
    end
    assign line_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        rise_pulse = 1'b0;
        unique case (state_q)
            EDGE_LOW: begin
                if (line_s) begin
                    state_d    = EDGE_HIGH;
                    rise_pulse = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!line_s) state_d = EDGE_LOW;
            end
        endcase
    end

    // R4: a rise is reported once per high level
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/ide_status_byte.sv
module ide_status_byte
    import ide_bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lane,
    input  logic       wr_err_clr,
    input  logic       wr_irq_clr,
    input  logic [1:0] wr_dma,
    input  logic       hw_err_set,
    input  logic       hw_irq_set,
    input  logic       engine_active,
    input  logic       simplex_strap,
    output logic [7:0] status,
    output logic [1:0] dma_capable
);
    logic       err_q, irq_q;
    logic [1:0] dma_q;

    // R5: a hardware set wins over a same-edge clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
            dma_q <= '0;
        end else begin
            if (hw_err_set)                  err_q <= 1'b1;
            else if (wr_lane && wr_err_clr)  err_q <= 1'b0;
            if (hw_irq_set)                  irq_q <= 1'b1;
            else if (wr_lane && wr_irq_clr)  irq_q <= 1'b0;
            if (wr_lane)                     dma_q <= wr_dma;
        end
    end

    always_comb begin
        status             = '0;
        status[SB_ACTIVE]  = engine_active;
        status[SB_ERR]     = err_q;
        status[SB_IRQ]     = irq_q;
        status[SB_DMA0]    = dma_q[0];
        status[SB_DMA1]    = dma_q[1];
        status[SB_SIMPLEX] = simplex_strap;
    end
    assign dma_capable = dma_q;

    a_r3_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err_set |=> err_q);
    a_r5_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq_set |=> irq_q);
    a_r7_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lane |=> $stable(dma_q));
    a_r11_irq_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lane && irq_q) |=> irq_q);
endmodule

// File: rtl/ide_prd_base_reg.sv
module ide_prd_base_reg
    import ide_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:2] wdata,
    output logic [DATA_W-1:0] base
);
    logic [DATA_W-1:2] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            if (be[0]) base_q[7:2] <= wdata[7:2];
            for (int b = 1; b < BE_W; b++)
                if (be[b]) base_q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end
    assign base = {base_q, 2'b00};

    a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_q));
endmodule

// File: rtl/ide_bm_status_regs.sv
module ide_bm_status_regs
    import ide_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_word_addr,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              engine_active,
    input  logic              error_pulse,
    input  logic              drive_irq,
    input  logic              simplex_strap,
    output logic [DATA_W-1:0] prd_base,
    output logic [1:0]        dma_capable
);
    localparam int LANE_LSB = STATUS_LANE * 8;

    logic       hit_status, hit_base, wr_lane, irq_rise;
    logic [7:0] status, wlane;

    assign hit_status = (bus_word_addr == ADDR_W'(STATUS_IDX));
    assign hit_base   = (bus_word_addr == ADDR_W'(BASE_IDX));
    assign wr_lane    = bus_wr && hit_status && bus_be[STATUS_LANE];
    assign wlane      = bus_wdata[LANE_LSB +: 8];

    ide_irq_edge_fsm u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (drive_irq),
        .rise_pulse (irq_rise)
    );

    ide_status_byte u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_lane       (wr_lane),
        .wr_err_clr    (wlane[SB_ERR]),
        .wr_irq_clr    (wlane[SB_IRQ]),
        .wr_dma        ({wlane[SB_DMA1], wlane[SB_DMA0]}),
        .hw_err_set    (error_pulse),
        .hw_irq_set    (irq_rise),
        .engine_active (engine_active),
        .simplex_strap (simplex_strap),
        .status        (status),
        .dma_capable   (dma_capable)
    );

    ide_prd_base_reg u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && hit_base),
        .be    (bus_be),
        .wdata (bus_wdata[DATA_W-1:2]),
        .base  (prd_base)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_status)    bus_rdata[LANE_LSB +: 8] = status;
        else if (hit_base) bus_rdata = prd_base;
    end

    a_r2_active_live: assert property (@(posedge clk) disable iff (!rst_n)
        hit_status |-> (bus_rdata[LANE_LSB + SB_ACTIVE] == engine_active));
    a_r8_simplex_live: assert property (@(posedge clk) disable iff (!rst_n)
        hit_status |-> (bus_rdata[LANE_LSB + SB_SIMPLEX] == simplex_strap));
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_status |-> (bus_rdata[LANE_LSB + 4 : LANE_LSB + 3] == 2'b00));
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_status && !hit_base) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_ide_bm_status_regs.sv
`timescale 1ns/1ps
module tb_ide_bm_status_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        eng = 1'b0, errp = 1'b0, irq = 1'b0, strap = 1'b0;
    logic [31:0] base_o;
    logic [1:0]  dma_o;

    int checks = 0, fails = 0;
    logic m_err = 0, m_irq = 0;
    logic [1:0]  m_dma = 0;
    logic [31:0] m_base = 0;

    always #2 clk = ~clk;

    ide_bm_status_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_word_addr(addr), .bus_wr(wr), .bus_be(be),
        .bus_wdata(wdata), .bus_rdata(rdata), .engine_active(eng), .error_pulse(errp),
        .drive_irq(irq), .simplex_strap(strap), .prd_base(base_o), .dma_capable(dma_o)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        if (a == 2) return {8'h0, strap, m_dma[1], m_dma[0], 2'b00, m_irq, m_err, eng, 16'h0};
        if (a == 3) return m_base;
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a);
        addr = a; #0.5;
        chk(req, rdata, exp_read(a));
    endtask

    task automatic model_write(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d, input logic ep);
        if (ep) m_err = 1;
        else if (a == 2 && b[2] && d[17]) m_err = 0;
        if (a == 2 && b[2]) begin
            if (d[18]) m_irq = 0;
            m_dma = d[22:21];
        end
        if (a == 3)
            for (int k = 0; k < 4; k++) if (b[k]) m_base[k*8 +: 8] = d[k*8 +: 8];
        m_base[1:0] = 2'b00;
    endtask

    task automatic cyc(input logic w, input logic [1:0] a, input logic [3:0] b, input logic [31:0] d, input logic ep);
        @(negedge clk);
        wr = w; addr = a; be = b; wdata = d; errp = ep;
        if (w) model_write(a, b, d, ep); else if (ep) m_err = 1;
        @(posedge clk); #1;
        wr = 0; errp = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1DE5));
        repeat (3) @(posedge clk);
        #1;
        rd_chk("R1 status after reset", 2);
        rd_chk("R1 base after reset", 3);
        @(negedge clk); rst_n = 1;

        // R2 / R8: live bits, writes ignored
        cyc(1, 2, 4'hF, 32'h0081_0000, 0);
        rd_chk("R2 active ignores write", 2);
        eng = 1; strap = 1; #0.5;
        rd_chk("R2 R8 live bits", 2);
        // R6 reserved bits
        cyc(1, 2, 4'h4, 32'h0018_0000, 0);
        chk("R6 reserved zero", {30'h0, rdata[20:19]}, 0);
        // R7 DMA flags
        cyc(1, 2, 4'h4, 32'h0060_0000, 0);
        chk("R7 dma out", {30'h0, dma_o}, 2'b11);
        rd_chk("R7 dma read", 2);
        // R11 lane not enabled
        cyc(1, 2, 4'hB, 32'h0000_0000, 0);
        rd_chk("R11 no lane no change", 2);
        // R3 error set and clear
        cyc(0, 2, 0, 0, 1);
        rd_chk("R3 error set", 2);
        cyc(1, 2, 4'h4, 32'h0060_0000, 0);
        rd_chk("R3 write 0 keeps error", 2);
        cyc(1, 2, 4'h4, 32'h0062_0000, 0);
        rd_chk("R3 write 1 clears error", 2);
        cyc(1, 2, 4'h4, 32'h0062_0000, 1);
        rd_chk("R5 error set wins", 2);
        // R4 interrupt edge timing
        @(negedge clk); irq = 1;
        @(posedge clk); #1; chk("R4 irq after edge 1", {31'h0, rdata[18]}, 0);
        @(posedge clk); #1; chk("R4 irq after edge 2", {31'h0, rdata[18]}, 0);
        @(posedge clk); #1; m_irq = 1; rd_chk("R4 irq after edge 3", 2);
        cyc(1, 2, 4'h4, 32'h0064_0000, 0);
        rd_chk("R4 clear with line high", 2);
        repeat (4) @(posedge clk); #1;
        rd_chk("R4 level does not re-set", 2);
        // R5 irq set with clear on same edge
        @(negedge clk); irq = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); irq = 1;
        @(posedge clk); @(posedge clk);
        cyc(1, 2, 4'h4, 32'h0064_0000, 0);
        m_irq = 1;
        rd_chk("R5 irq set wins", 2);
        // R9 base byte enables
        cyc(1, 3, 4'hF, 32'hFFFF_FFFF, 0);
        rd_chk("R9 base full write", 3);
        chk("R9 base out", base_o, 32'hFFFF_FFFC);
        cyc(1, 3, 4'h5, 32'h1234_5678, 0);
        rd_chk("R9 base byte enables", 3);
        // R10 unmapped
        rd_chk("R10 word 0", 0);
        rd_chk("R10 word 1", 1);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a; logic [3:0] b; logic [31:0] d; logic ep;
            a = 2'($urandom_range(3, 0));
            b = 4'($urandom);
            d = $urandom;
            ep = ($urandom_range(7, 0) == 0);
            eng = 1'($urandom);
            cyc(1'($urandom), a, b, d, ep);
            rd_chk("R9 R3 R7 R10 random read", 2'($urandom_range(3, 0)));
            chk("R7 random dma out", {30'h0, dma_o}, {30'h0, m_dma});
            chk("R9 random base out", base_o, m_base);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule